// File: doc/BRIEF.md
# GPIO Pin Event Detector with Sticky Status

This block holds the event logic for one general-purpose pin. It watches an input that has already been debounced. According to a small configuration word, it records qualifying events into two sticky flags: an interrupt flag and a wake flag. An interrupt request goes out only when the pin's interrupt is both enabled and unmasked. The same register word also holds the pin's output-enable and output-value controls. On readback it returns the live pin level.

Software sees one register through a write strobe and a combinational read port. A write loads every configuration field. The same write returns ones to the status flags it wants to clear; there is no separate acknowledge step. Combining the flags of many pins is left to the surrounding logic.

Top module: `pin_evt_ctrl`

## Requirements
- R1: After reset every configuration field and both status flags are 0, so the request, pending, output-enable and output-value outputs are all 0.
- R2: In edge mode (bit 0 = 0) with polarity field bits [2:1] = 01, a 0-to-1 change of `pin_in` sets the interrupt flag (bit 9) at the next clock edge, provided interrupt enable (bit 3) is 1. A 1-to-0 change sets nothing.
- R3: In edge mode, polarity code 00 records falling edges and code 10 records both edges. Reserved code 11 records no edge at all.
- R4: In level mode (bit 0 = 1), code 01 records an event on every cycle `pin_in` is 1 and code 00 on every cycle it is 0. A clear therefore does not take while the level persists. The flag stays set after the level goes away. Codes 10 and 11 record nothing in level mode.
- R5: `irq_req` is 1 only while the interrupt flag, interrupt enable (bit 3) and the unmask bit (bit 4, 1 = unmasked) are all 1. A masked pin still sets its flag.
- R6: With interrupt enable at 0, events do not set the interrupt flag.
- R7: Writing 1 to a status bit clears that flag at the next edge. Writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the flag set.
- R8: With wake enable (bit 5) at 1, an event sets the wake flag (bit 10). `evt_pend` is 1 whenever either flag is set. Writing 1 to bit 10 clears the wake flag.
- R9: Read bit 8 returns `pin_in` when output enable (bit 6) is 0 and the output value (bit 7) when it is 1. `pad_oe` and `pad_out` follow bits 6 and 7.
- R10: A write that changes the mode bit or the polarity field records no event in that cycle. An input change coinciding with that write is absorbed into the edge history and never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 1 | Debounced pin level |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data: configuration fields plus write-one-to-clear status bits |
| rd_data | output | REG_W | Register readback: configuration, pin status and both flags |
| irq_req | output | 1 | Interrupt request for this pin |
| evt_pend | output | 1 | Either status flag set |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |

## Verification
Flags and everything derived from them (`irq_req`, `evt_pend`, read bits 9 and 10) change at the first clock edge after the input change or write that causes them. Pin status on read bit 8 follows `pin_in` combinationally within the same cycle. The driver applies each stimulus half a period before an edge and queues the expected values for that edge. The monitor compares them 2 ns after the edge, while the stimulus is still held. Every check therefore sees exactly one edge's worth of state change.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

   // register field positions
   localparam int unsigned FLD_LVL  = 0;
   localparam int unsigned FLD_POL  = 1;   // two bits
   localparam int unsigned POL_W    = 2;
   localparam int unsigned FLD_IEN  = 3;
   localparam int unsigned FLD_IUNM = 4;
   localparam int unsigned FLD_WEN  = 5;
   localparam int unsigned FLD_OE   = 6;
   localparam int unsigned FLD_OV   = 7;
   localparam int unsigned FLD_PIN  = 8;
   localparam int unsigned FLD_ISTS = 9;
   localparam int unsigned FLD_WSTS = 10;
   localparam int unsigned FLD_USED = 11;

   // sticky flag indices
   localparam int unsigned N_FLAG    = 2;
   localparam int unsigned FLAG_INT  = 0;
   localparam int unsigned FLAG_WAKE = 1;

   typedef enum logic [POL_W-1:0] {
      POL_LOW_FALL  = 2'b00,
      POL_HIGH_RISE = 2'b01,
      POL_ANY_EDGE  = 2'b10,
      POL_RSVD      = 2'b11
   } pol_e;

   typedef struct packed {
      logic lvl;
      pol_e pol;
      logic ien;
      logic iunm;
      logic wen;
      logic oe;
      logic ov;
   } pin_cfg_t;

endpackage

// File: rtl/pin_trig_detect.sv
module pin_trig_detect
   import pin_evt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic lvl_mode,
   input  pol_e pol,
   input  logic reload,
   output logic evt
);

   logic prev_q;
   logic rise, fall, edge_hit, lvl_hit;

   // history tracks the input every cycle, so a reload simply discards
   // the comparison made in that cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= din;
   end

   assign rise = din & ~prev_q;
   assign fall = ~din & prev_q;

   always_comb begin
      unique case (pol)
         POL_LOW_FALL:  edge_hit = fall;
         POL_HIGH_RISE: edge_hit = rise;
         POL_ANY_EDGE:  edge_hit = rise | fall;
         default:       edge_hit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (pol)
         POL_LOW_FALL:  lvl_hit = ~din;
         POL_HIGH_RISE: lvl_hit = din;
         default:       lvl_hit = 1'b0;
      endcase
   end

   assign evt = ~reload & (lvl_mode ? lvl_hit : edge_hit);

   // reserved code never yields an event (R3)
   p_rsvd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pol == POL_RSVD) |-> !evt);

   // a reload cycle never yields an event (R10)
   p_reload_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> !evt);

endmodule

// File: rtl/pin_sts_flag.sv
module pin_sts_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

   p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

endmodule

// File: rtl/pin_evt_ctrl.sv
module pin_evt_ctrl
   import pin_evt_pkg::*;
#(
   parameter int unsigned REG_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq_req,
   output logic             evt_pend,
   output logic             pad_oe,
   output logic             pad_out
);

   localparam int unsigned SPARE_W = REG_W - FLD_USED;

   generate
      if (REG_W < FLD_USED) begin : g_bad_width
         $error("pin_evt_ctrl: REG_W must hold all %0d fields", FLD_USED);
      end
   endgenerate

   pin_cfg_t          cfg_q, cfg_d;
   logic              trig_chg;
   logic              evt;
   logic              pin_sts;
   logic [N_FLAG-1:0] flg_set, flg_clr, flg_q;
   logic              unused_wr;

   always_comb begin
      cfg_d.lvl  = wr_data[FLD_LVL];
      cfg_d.pol  = pol_e'(wr_data[FLD_POL +: POL_W]);
      cfg_d.ien  = wr_data[FLD_IEN];
      cfg_d.iunm = wr_data[FLD_IUNM];
      cfg_d.wen  = wr_data[FLD_WEN];
      cfg_d.oe   = wr_data[FLD_OE];
      cfg_d.ov   = wr_data[FLD_OV];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_en) cfg_q <= cfg_d;
   end

   assign trig_chg = wr_en &&
                     ({cfg_d.lvl, cfg_d.pol} != {cfg_q.lvl, cfg_q.pol});

   pin_trig_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (pin_in),
      .lvl_mode (cfg_q.lvl),
      .pol      (cfg_q.pol),
      .reload   (trig_chg),
      .evt      (evt)
   );

   assign flg_set[FLAG_INT]  = evt & cfg_q.ien;
   assign flg_set[FLAG_WAKE] = evt & cfg_q.wen;
   assign flg_clr[FLAG_INT]  = wr_en & wr_data[FLD_ISTS];
   assign flg_clr[FLAG_WAKE] = wr_en & wr_data[FLD_WSTS];

   generate
      for (genvar gi = 0; gi < N_FLAG; gi++) begin : g_flag
         pin_sts_flag u_flg (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flg_set[gi]),
            .clr   (flg_clr[gi]),
            .flag  (flg_q[gi])
         );
      end
   endgenerate

   assign irq_req  = flg_q[FLAG_INT] & cfg_q.ien & cfg_q.iunm;
   assign evt_pend = |flg_q;
   assign pad_oe   = cfg_q.oe;
   assign pad_out  = cfg_q.ov;
   assign pin_sts  = cfg_q.oe ? cfg_q.ov : pin_in;

   always_comb begin
      rd_data                      = '0;
      rd_data[FLD_LVL]             = cfg_q.lvl;
      rd_data[FLD_POL +: POL_W]    = cfg_q.pol;
      rd_data[FLD_IEN]             = cfg_q.ien;
      rd_data[FLD_IUNM]            = cfg_q.iunm;
      rd_data[FLD_WEN]             = cfg_q.wen;
      rd_data[FLD_OE]              = cfg_q.oe;
      rd_data[FLD_OV]              = cfg_q.ov;
      rd_data[FLD_PIN]             = pin_sts;
      rd_data[FLD_ISTS]            = flg_q[FLAG_INT];
      rd_data[FLD_WSTS]            = flg_q[FLAG_WAKE];
   end

   generate
      if (SPARE_W > 0) begin : g_spare
         assign unused_wr = ^wr_data[REG_W-1:FLD_USED];
      end else begin : g_nospare
         assign unused_wr = 1'b0;
      end
   endgenerate

   // a write changing trigger fields leaves a clear flag clear (R10)
   p_trig_chg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_chg && !flg_q[FLAG_INT]) |=> !flg_q[FLAG_INT]);

   // disabled interrupt never raises its flag (R6)
   p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.ien && !flg_q[FLAG_INT]) |=> !flg_q[FLAG_INT]);

   // masked pin never requests (R5)
   p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.iunm |-> !irq_req);

   // a set wake flag is always pending (R8)
   p_wake_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flg_q[FLAG_WAKE] |-> evt_pend);

endmodule

// File: tb/sim_pin_evt_ctrl.sv
module sim_pin_evt_ctrl;

   localparam int unsigned REG_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pin_in = 1'b0;
   logic             wr_en = 1'b0;
   logic [REG_W-1:0] wr_data = '0;
   logic [REG_W-1:0] rd_data;
   logic             irq_req, evt_pend, pad_oe, pad_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   typedef struct {
      logic [6:0] v;
      string      tag;
   } exp_t;

   exp_t sbq[$];

   always #4 clk = ~clk;   // 125 MHz

   pin_evt_ctrl #(.REG_W(REG_W)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .irq_req(irq_req), .evt_pend(evt_pend),
      .pad_oe(pad_oe), .pad_out(pad_out)
   );

   // observed vector: {int flag, wake flag, pin status, irq, pending, oe, ov}
   function automatic logic [6:0] observe();
      return {rd_data[9], rd_data[10], rd_data[8], irq_req, evt_pend, pad_oe, pad_out};
   endfunction

   // register word: bit0 level, [2:1] polarity, 3 ien, 4 unmask, 5 wake en,
   // 6 oe, 7 ov, 9 clear int flag, 10 clear wake flag
   function automatic logic [REG_W-1:0] cw(input logic lvl, input logic [1:0] pol,
      input logic ien, input logic unm, input logic wen, input logic oe,
      input logic ov, input logic ci, input logic cwk);
      logic [REG_W-1:0] w;
      w = '0;
      w[0] = lvl; w[2:1] = pol; w[3] = ien; w[4] = unm; w[5] = wen;
      w[6] = oe; w[7] = ov; w[9] = ci; w[10] = cwk;
      return w;
   endfunction

   // driver: one cycle of stimulus, expected result queued for that edge
   task automatic cyc(input logic d, input logic we, input logic [REG_W-1:0] wd,
                      input logic [6:0] ev, input string tag);
      exp_t e;
      @(negedge clk);
      pin_in  = d;
      wr_en   = we;
      wr_data = wd;
      @(posedge clk);
      e.v = ev;
      e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: compare 2 ns after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            exp_t e;
            logic [6:0] got;
            e = sbq.pop_front();
            got = observe();
            n_chk++;
            if (got !== e.v) begin
               n_fail++;
               $display("FAIL %s: got %b expected %b", e.tag, got, e.v);
            end
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cyc(0, 0, '0, 7'b0000000, "R1 reset");
      // R2 rising edge mode
      cyc(0, 1, cw(0,2'b01,1,1,0,0,0,0,0), 7'b0000000, "R2 config");
      cyc(1, 0, '0, 7'b1011100, "R2 rise sets");
      cyc(0, 0, '0, 7'b1001100, "R2 fall ignored");
      // R7 write-one-to-clear
      cyc(0, 1, cw(0,2'b01,1,1,0,0,0,1,0), 7'b0000000, "R7 clear");
      cyc(1, 1, cw(0,2'b01,1,1,0,0,0,1,0), 7'b1011100, "R7 event wins");
      cyc(1, 1, cw(0,2'b01,1,1,0,0,0,0,0), 7'b1011100, "R7 zero keeps");
      // R5 mask
      cyc(1, 1, cw(0,2'b01,1,0,0,0,0,1,0), 7'b0010000, "R5 mask+clear");
      cyc(0, 0, '0, 7'b0000000, "R5 idle");
      cyc(1, 0, '0, 7'b1010100, "R5 masked sets flag");
      cyc(1, 1, cw(0,2'b01,1,1,0,0,0,0,0), 7'b1011100, "R5 unmask requests");
      // R3 other polarities
      cyc(1, 1, cw(0,2'b00,1,1,0,0,0,1,0), 7'b0010000, "R3 falling cfg");
      cyc(0, 0, '0, 7'b1001100, "R3 falling sets");
      cyc(0, 1, cw(0,2'b10,1,1,0,0,0,1,0), 7'b0000000, "R3 both cfg");
      cyc(1, 0, '0, 7'b1011100, "R3 both rise");
      cyc(1, 1, cw(0,2'b10,1,1,0,0,0,1,0), 7'b0010000, "R3 both clear");
      cyc(0, 0, '0, 7'b1001100, "R3 both fall");
      cyc(0, 1, cw(0,2'b11,1,1,0,0,0,1,0), 7'b0000000, "R3 reserved cfg");
      cyc(1, 0, '0, 7'b0010000, "R3 reserved rise");
      cyc(0, 0, '0, 7'b0000000, "R3 reserved fall");
      // R10 trigger change absorbs coincident edge
      cyc(1, 1, cw(0,2'b01,1,1,0,0,0,0,0), 7'b0010000, "R10 edge with cfg change");
      cyc(1, 0, '0, 7'b0010000, "R10 no late edge");
      // R6 interrupt disabled
      cyc(0, 1, cw(0,2'b01,0,1,0,0,0,0,0), 7'b0000000, "R6 disable");
      cyc(1, 0, '0, 7'b0010000, "R6 no flag");
      // R8 wake
      cyc(0, 1, cw(0,2'b01,0,1,1,0,0,0,0), 7'b0000000, "R8 wake cfg");
      cyc(1, 0, '0, 7'b0110100, "R8 wake sets");
      cyc(1, 1, cw(0,2'b01,0,1,1,0,0,0,1), 7'b0010000, "R8 wake clear");
      // R4 level mode
      cyc(1, 1, cw(1,2'b01,1,1,0,0,0,0,0), 7'b0010000, "R4 level cfg");
      cyc(1, 0, '0, 7'b1011100, "R4 high sets");
      cyc(1, 1, cw(1,2'b01,1,1,0,0,0,1,0), 7'b1011100, "R4 clear while active");
      cyc(0, 0, '0, 7'b1001100, "R4 sticky after level");
      cyc(0, 1, cw(1,2'b01,1,1,0,0,0,1,0), 7'b0000000, "R4 clear inactive");
      cyc(0, 1, cw(1,2'b00,1,1,0,0,0,0,0), 7'b0000000, "R4 low cfg");
      cyc(0, 0, '0, 7'b1001100, "R4 low sets");
      cyc(0, 1, cw(1,2'b10,1,1,0,0,0,1,0), 7'b0000000, "R4 code10 cfg");
      cyc(1, 0, '0, 7'b0010000, "R4 code10 high none");
      cyc(0, 0, '0, 7'b0000000, "R4 code10 low none");
      // R9 output path
      cyc(0, 1, cw(1,2'b10,0,0,0,1,1,0,0), 7'b0010011, "R9 drive high");
      cyc(1, 1, cw(1,2'b10,0,0,0,1,0,0,0), 7'b0000010, "R9 drive low");
      cyc(1, 0, '0, 7'b0000010, "R9 hold");
      wait (sbq.size() == 0);
      repeat (2) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule